// File: doc/BRIEF.md
# Host Command Queue with Status Word

This block sits between a host register port and a drawing engine. The host posts commands, each made of a register index and a 32-bit data word. The block holds them in a first-in first-out queue and hands them to the engine in order, at most one per clock, whenever the engine signals ready. A single 32-bit status word reports the queue's condition back to the host.

The status word carries several fields:

- The number of free queue slots.
- A raster-busy flag, set while the queue holds commands or the engine reports work in flight.
- A frame-buffer-busy flag, taken from the memory side.
- Two sticky error flags: one for a command lost to a full queue, and one for a failed host read.

Host software treats the engine as idle only when both busy flags are low. It keeps a safety margin of 8 slots below the reported free count before posting further commands. The error flags clear only when the host writes a one to their bit positions.

Top module: `cmdq_front`

## Requirements
- R1: After reset the queue is empty, `eng_valid` is 0, and the status word equals DEPTH in bits 11:0 with every other bit 0.
- R2: Status bits 11:0 equal DEPTH minus the number of queued commands. The field updates on the clock edge that accepts or removes a command.
- R3: Commands reach `eng_idx`/`eng_data` in the order they were accepted, with index and data unchanged. One command leaves on each edge where `eng_valid` and `eng_ready` are both high.
- R4: A command presented while the queue holds DEPTH entries is discarded, even if a command leaves on the same edge. The discard sets status bit 31, which then stays 1 until cleared.
- R5: A pulse on `rd_err` sets status bit 30, which then stays 1 until cleared.
- R6: A status write with bit 31 (or bit 30) set to 1 clears that flag on the next edge. A 0 in either position leaves that flag as it was, and the other written bits have no effect.
- R7: If a flag's set event and its clear request land on the same edge, the flag ends up 1.
- R8: Status bit 25 is 1 on the edge after the queue becomes non-empty or `eng_busy` is sampled high. It is 0 only when the queue is empty and `eng_busy` was low at the previous edge.
- R9: Status bit 24 equals `fb_busy` as sampled at the previous clock edge.
- R10: A command accepted on the same edge that another leaves leaves the free count unchanged, and the new command joins behind the remaining ones.
- R11: Status bits 29:26 and 23:12 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Host posts a command this cycle |
| cmd_idx | input | IDX_W | Register index of the posted command |
| cmd_data | input | DATA_W | Data word of the posted command |
| stat_wr | input | 1 | Host writes the status word (write-one-to-clear) |
| stat_wdata | input | 32 | Value written to the status word |
| rd_err | input | 1 | Pulse reporting a failed host read |
| status | output | 32 | Packed status word |
| eng_valid | output | 1 | Head of the queue is valid |
| eng_idx | output | IDX_W | Register index at the head |
| eng_data | output | DATA_W | Data word at the head |
| eng_ready | input | 1 | Engine takes the head on this edge |
| eng_busy | input | 1 | Engine is working on a command |
| fb_busy | input | 1 | Frame-buffer side is busy |

## Verification
Every status field is a register output, so the effect of a command, status write or error pulse is due one clock edge after it is driven. This holds for the free count, the sticky flags and both busy bits, which are sampled one edge before they appear. The queue head is combinational from storage, so it is checked in the same cycle as the edge that popped it has settled. The bench drives every input on the falling edge and compares on the following falling edge, exactly one rising edge later. Checks of a flag's stickiness wait further idle cycles before sampling again.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    localparam int STAT_W       = 32;
    localparam int FREE_W       = 12;
    localparam int FB_BUSY_BIT  = 24;
    localparam int RAS_BUSY_BIT = 25;
    localparam int RDERR_BIT    = 30;
    localparam int OVF_BIT      = 31;

    typedef struct packed {
        logic ovf;
        logic rderr;
    } err_flags_t;

    typedef struct packed {
        logic fb;
        logic eng;
    } busy_smp_t;
endpackage

// File: rtl/cmdq_store.sv
module cmdq_store #(
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic              head_valid,
    output logic [IDX_W-1:0]  head_idx,
    output logic [DATA_W-1:0] head_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic              drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int ENT_W = IDX_W + DATA_W;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] mem;
        logic [PTR_W-1:0]            wr_ptr;
        logic [PTR_W-1:0]            rd_ptr;
        logic [CNT_W-1:0]            count;
    } store_t;

    store_t st_d, st_q;
    logic   full, empty, do_push, do_pop;

    always_comb begin
        full    = (st_q.count == FULL_CNT);
        empty   = (st_q.count == '0);
        do_push = push_req && !full;
        do_pop  = pop_req && !empty;
        st_d    = st_q;
        if (do_push) begin
            st_d.mem[st_q.wr_ptr] = {push_idx, push_data};
            st_d.wr_ptr = (st_q.wr_ptr == LAST_PTR) ? '0 : st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST_PTR) ? '0 : st_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_valid = !empty;
    assign {head_idx, head_data} = st_q.mem[st_q.rd_ptr];
    assign level = st_q.count;
    assign drop  = push_req && full;

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= FULL_CNT);
    // R10
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && do_pop) |=> $stable(st_q.count));
    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |=> $stable(st_q.wr_ptr));
    // R3
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop && !do_push) |=> (st_q.count == $past(st_q.count) - 1'b1));
endmodule

// File: rtl/cmdq_errs.sv
module cmdq_errs
    import cmdq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_evt,
    input  logic rderr_evt,
    input  logic clr_ovf,
    input  logic clr_rderr,
    output err_flags_t flags
);
    err_flags_t fl_d, fl_q;

    always_comb begin
        fl_d       = fl_q;
        fl_d.ovf   = (fl_q.ovf   && !clr_ovf)   || ovf_evt;
        fl_d.rderr = (fl_q.rderr && !clr_rderr) || rderr_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags = fl_q;

    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> fl_q.ovf);
    // R5
    rderr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rderr_evt |=> fl_q.rderr);
    // R6
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !ovf_evt) |=> !fl_q.ovf);
    // R6
    rderr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rderr && !rderr_evt) |=> !fl_q.rderr);
    // R6
    ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.ovf && !clr_ovf) |=> fl_q.ovf);
endmodule

// File: rtl/cmdq_busy.sv
module cmdq_busy
    import cmdq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fb_busy_in,
    input  logic eng_busy_in,
    input  logic queue_nonempty,
    output logic raster_busy,
    output logic frame_busy
);
    busy_smp_t smp_d, smp_q;

    always_comb begin
        smp_d.fb  = fb_busy_in;
        smp_d.eng = eng_busy_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign raster_busy = smp_q.eng || queue_nonempty;
    assign frame_busy  = smp_q.fb;

    // R9
    fb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_busy_in |=> frame_busy);
    // R8
    eng_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy_in |=> raster_busy);
endmodule

// File: rtl/cmdq_front.sv
module cmdq_front
    import cmdq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              stat_wr,
    input  logic [31:0]       stat_wdata,
    input  logic              rd_err,
    output logic [31:0]       status,
    output logic              eng_valid,
    output logic [IDX_W-1:0]  eng_idx,
    output logic [DATA_W-1:0] eng_data,
    input  logic              eng_ready,
    input  logic              eng_busy,
    input  logic              fb_busy
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] level;
    logic             drop;
    logic             raster_busy, frame_busy;
    err_flags_t       flags;
    logic [FREE_W-1:0] free_slots;

    cmdq_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (cmd_valid),
        .push_idx   (cmd_idx),
        .push_data  (cmd_data),
        .pop_req    (eng_ready),
        .head_valid (eng_valid),
        .head_idx   (eng_idx),
        .head_data  (eng_data),
        .level      (level),
        .drop       (drop)
    );

    cmdq_errs u_errs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovf_evt   (drop),
        .rderr_evt (rd_err),
        .clr_ovf   (stat_wr && stat_wdata[OVF_BIT]),
        .clr_rderr (stat_wr && stat_wdata[RDERR_BIT]),
        .flags     (flags)
    );

    cmdq_busy u_busy (
        .clk            (clk),
        .rst_n          (rst_n),
        .fb_busy_in     (fb_busy),
        .eng_busy_in    (eng_busy),
        .queue_nonempty (level != '0),
        .raster_busy    (raster_busy),
        .frame_busy     (frame_busy)
    );

    always_comb begin
        free_slots                = FREE_W'(DEPTH) - FREE_W'(level);
        status                    = '0;
        status[FREE_W-1:0]        = free_slots;
        status[FB_BUSY_BIT]       = frame_busy;
        status[RAS_BUSY_BIT]      = raster_busy;
        status[RDERR_BIT]         = flags.rderr;
        status[OVF_BIT]           = flags.ovf;
    end

    // R8
    cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> status[RAS_BUSY_BIT]);
    // R4
    full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && status[FREE_W-1:0] == '0) |=> status[OVF_BIT]);
    // R11
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[29:26] == '0) && (status[23:12] == '0));
endmodule

// File: tb/sim_cmdq_front.sv
module sim_cmdq_front;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int IDX_W  = 8;
    localparam int DATA_W = 32;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, stat_wr = 0, rd_err = 0;
    logic eng_ready = 0, eng_busy = 0, fb_busy = 0;
    logic [IDX_W-1:0]  cmd_idx = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic [31:0] stat_wdata = '0;
    logic [31:0] status;
    logic eng_valid;
    logic [IDX_W-1:0]  eng_idx;
    logic [DATA_W-1:0] eng_data;

    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdq_front #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
        .cmd_data(cmd_data), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .rd_err(rd_err), .status(status), .eng_valid(eng_valid),
        .eng_idx(eng_idx), .eng_data(eng_data), .eng_ready(eng_ready),
        .eng_busy(eng_busy), .fb_busy(fb_busy)
    );

    function automatic logic [31:0] exp_stat(int free, bit rb, bit fb, bit re, bit ov);
        return {ov, re, 4'b0, rb, fb, 12'b0, 12'(free)};
    endfunction

    function automatic logic [DATA_W-1:0] pat(int i);
        return DATA_W'(32'h5A00_0000 + i * 32'h0001_0203);
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 status", status, exp_stat(DEPTH, 0, 0, 0, 0));
        chk("R1 eng_valid", eng_valid, 0);
    endtask

    task automatic t_fill();
        eng_ready = 0;
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 free while filling", status[11:0], DEPTH - i);
            cmd_valid = 1; cmd_idx = IDX_W'(i); cmd_data = pat(i);
            @(negedge clk);
        end
        cmd_valid = 0;
        chk("R2/R8 full status", status, exp_stat(0, 1, 0, 0, 0));
    endtask

    task automatic t_overflow();
        cmd_valid = 1; cmd_idx = 8'hEE; cmd_data = 32'hDEAD_BEEF;
        @(negedge clk);
        cmd_valid = 0;
        chk("R4 drop sets flag", status, exp_stat(0, 1, 0, 0, 1));
        repeat (3) @(negedge clk);
        chk("R4 flag sticky", status[31], 1);
    endtask

    task automatic t_drain();
        eng_ready = 1;
        for (int i = 0; i < DEPTH; i++) begin
            chk("R3 head valid", eng_valid, 1);
            chk("R3 head idx", eng_idx, IDX_W'(i));
            chk("R3 head data", eng_data, pat(i));
            chk("R2 free while draining", status[11:0], i);
            @(negedge clk);
        end
        chk("R4 dropped entry absent", eng_valid, 0);
        chk("R2/R8 empty status", status, exp_stat(DEPTH, 0, 0, 0, 1));
        eng_ready = 0;
    endtask

    task automatic t_w1c();
        stat_wr = 1; stat_wdata = 32'h3FFF_FFFF;
        @(negedge clk);
        stat_wr = 0;
        chk("R6 zero bits keep flag", status, exp_stat(DEPTH, 0, 0, 0, 1));
        stat_wr = 1; stat_wdata = 32'h8000_0000;
        @(negedge clk);
        stat_wr = 0;
        chk("R6 clear ovf", status, exp_stat(DEPTH, 0, 0, 0, 0));
        rd_err = 1;
        @(negedge clk);
        rd_err = 0;
        chk("R5 read error set", status, exp_stat(DEPTH, 0, 0, 1, 0));
        repeat (2) @(negedge clk);
        chk("R5 read error sticky", status[30], 1);
        stat_wr = 1; stat_wdata = 32'h8000_0000;
        @(negedge clk);
        stat_wr = 0;
        chk("R6 ovf clear leaves rderr", status[30], 1);
        stat_wr = 1; stat_wdata = 32'h4000_0000;
        @(negedge clk);
        stat_wr = 0;
        chk("R6 clear rderr", status, exp_stat(DEPTH, 0, 0, 0, 0));
    endtask

    task automatic t_set_wins();
        eng_ready = 0;
        for (int i = 0; i < DEPTH; i++) begin
            cmd_valid = 1; cmd_idx = IDX_W'(i); cmd_data = pat(i);
            @(negedge clk);
        end
        cmd_valid = 1; stat_wr = 1; stat_wdata = 32'hC000_0000; rd_err = 1;
        @(negedge clk);
        cmd_valid = 0; stat_wr = 0; rd_err = 0;
        chk("R7 set beats clear", status, exp_stat(0, 1, 0, 1, 1));
        stat_wr = 1; stat_wdata = 32'hC000_0000; eng_ready = 1;
        @(negedge clk);
        stat_wr = 0;
        repeat (DEPTH) @(negedge clk);
        eng_ready = 0;
        chk("R6 both cleared, queue empty", status, exp_stat(DEPTH, 0, 0, 0, 0));
    endtask

    task automatic t_simul();
        eng_ready = 1;
        cmd_valid = 1; cmd_idx = 8'h11; cmd_data = 32'h1111_0000;
        @(negedge clk);
        chk("R3 single head", eng_idx, 8'h11);
        cmd_idx = 8'h22; cmd_data = 32'h2222_0000;
        @(negedge clk);
        cmd_valid = 0;
        chk("R10 free unchanged", status[11:0], DEPTH - 1);
        chk("R10 new head", eng_data, 32'h2222_0000);
        @(negedge clk);
        eng_ready = 0;
        chk("R10 drained", status, exp_stat(DEPTH, 0, 0, 0, 0));
    endtask

    task automatic t_busy();
        eng_busy = 1;
        chk("R8 not yet sampled", status[25], 0);
        @(negedge clk);
        chk("R8 engine busy", status, exp_stat(DEPTH, 1, 0, 0, 0));
        eng_busy = 0; fb_busy = 1;
        @(negedge clk);
        chk("R9 fb busy", status, exp_stat(DEPTH, 0, 1, 0, 0));
        fb_busy = 0;
        @(negedge clk);
        chk("R9/R11 idle", status, exp_stat(DEPTH, 0, 0, 0, 0));
    endtask

    initial begin
        t_reset();
        t_fill();
        t_overflow();
        t_drain();
        t_w1c();
        t_set_wins();
        t_simul();
        t_busy();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule